// File: doc/BRIEF.md
# USB Endpoint Handshake and Buffer Command Controller

This block holds the handshake state for six USB device endpoint buffers. They are arranged as three control pairs, and each pair has one OUT buffer and one IN buffer. A microcontroller drives a byte-wide command port. On that port it selects an endpoint, marks an IN buffer as loaded, frees an OUT buffer, stalls or re-initialises an endpoint, and confirms that it has seen a SETUP packet.

The serial interface engine reports three kinds of bus event: a SETUP packet, a completed OUT data packet, and an IN token. For each event the block returns a one-cycle handshake (ACK, NAK or STALL). For IN tokens it also returns the DATA0/DATA1 toggle to transmit. The block keeps a full flag, a stall flag and a data toggle for every endpoint. After a SETUP it holds a per-pair lock that blocks the buffer-loading and buffer-freeing commands until the microcontroller confirms.

Top module: `usb_ep_hs_ctrl`

## Requirements
- R1: After reset, no endpoint is stalled, every buffer is empty, every toggle is DATA0, every setup lock is clear and hs_valid is low.
- R2: Each bus event produces exactly one handshake on hs_valid/hs_code in the next cycle. The encoding is ACK=2'b00, NAK=2'b01, STALL=2'b10. A pair's OUT endpoint is 2p (even number) and its IN endpoint is 2p+1 (odd number).
- R3: A completed OUT packet arrives on a non-stalled, empty OUT buffer, and its PID toggle (bus_pid_data1) equals the expected toggle. The block answers ACK, sets the full flag and flips the expected toggle. Every later OUT packet to that buffer gets NAK while the flag is set.
- R4: An OUT packet whose PID toggle differs from the expected toggle is answered with ACK. Its data is dropped: the full flag stays clear and the toggle is unchanged.
- R5: Command 0xF2 (no data byte) clears the full flag of the selected endpoint, and new OUT packets are then accepted.
- R6: Command 0xFA (no data byte) sets the full flag of the selected endpoint. An IN token on a full, non-stalled IN buffer gets ACK with hs_data1 equal to the current toggle. The flag then clears and the toggle flips. An IN token on an empty IN buffer gets NAK.
- R7: Command bytes 0x00 to 0x05 select endpoint 0 to 5. Other bytes in the range 0x00 to 0x3F are ignored.
- R8: Command 0x40+e, with e from 0 to 5, is followed by one data byte. If bit 0 of that byte is 1, endpoint e is stalled and answers its tokens with STALL. Bits 7 to 1 are ignored. A data byte with no pending 0x40+e command is ignored.
- R9: If that data byte has bit 0 equal to 0, endpoint e is re-initialised: its stall flag clears, its buffer is flushed and its toggle returns to DATA0. This happens even when the endpoint was not stalled.
- R10: A SETUP on pair p is answered with ACK. It clears both stall flags of the pair and marks the OUT buffer full. It flushes the IN buffer, sets both toggles to DATA1 and raises setup_lock[p].
- R11: While setup_lock[p] is high, 0xFA and 0xF2 aimed at either endpoint of pair p are ignored. Command 0xF1 (no data byte) clears the lock of the selected endpoint's pair.
- R12: When a bus event and a command fall in the same cycle, the bus event is applied first. A 0xFA issued in the same cycle as a SETUP on its pair is therefore ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Byte present on the command port |
| cmd_is_data | input | 1 | 1 for a data byte, 0 for a command code |
| cmd_byte | input | 8 | Command code or data byte |
| bus_setup | input | 1 | SETUP packet received on bus_pair |
| bus_out_done | input | 1 | OUT data packet completed on bus_pair |
| bus_in_token | input | 1 | IN token received on bus_pair |
| bus_pair | input | 2 | Control pair the bus event refers to |
| bus_pid_data1 | input | 1 | PID of the completed OUT packet is DATA1 |
| hs_valid | output | 1 | Handshake valid (one cycle after the event) |
| hs_code | output | 2 | Handshake code: ACK 00, NAK 01, STALL 10 |
| hs_data1 | output | 1 | Toggle to send with an ACKed IN: 1 is DATA1 |
| setup_lock | output | 3 | Per-pair post-SETUP command lock |

## Verification
The assertions rely on two properties of the inputs. First, the serial engine reports at most one bus event per cycle. Second, bus_pair names an existing pair whenever an event is raised. A dedicated property checks the first of these. The random stimulus draws a single event kind per step, with the pair index taken modulo three. Command bytes come from the defined codes plus stray values, and data bytes arrive both with and without a pending status command. This keeps the stimulus inside those input limits while still reaching the ignore paths.

// File: rtl/ephs_pkg.sv
package ephs_pkg;

    typedef enum logic [1:0] {
        HS_ACK   = 2'b00,
        HS_NAK   = 2'b01,
        HS_STALL = 2'b10
    } hs_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_VALIDATE,
        OP_CLEAR,
        OP_ACKSETUP,
        OP_STATUS
    } op_e;

    localparam logic [7:0] CMD_STAT_BASE = 8'h40;
    localparam logic [7:0] CMD_VALIDATE  = 8'hFA;
    localparam logic [7:0] CMD_CLEAR     = 8'hF2;
    localparam logic [7:0] CMD_ACKSETUP  = 8'hF1;

    typedef struct packed {
        logic [1:0] stall;
        logic [1:0] full;
        logic [1:0] tog;
        logic       lock;
        logic       hs_valid;
        hs_e        hs_code;
        logic       hs_data1;
    } pair_st_t;

endpackage

// File: rtl/ephs_cmd_decode.sv
module ephs_cmd_decode
    import ephs_pkg::*;
#(
    parameter int NUM_EP = 6,
    parameter int EP_W   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic            cmd_is_data,
    input  logic [7:0]      cmd_byte,
    output op_e             op_o,
    output logic [EP_W-1:0] op_ep_o,
    output logic            op_stall_o
);

    localparam logic [7:0] NUM_EP_B = 8'(NUM_EP);

    typedef struct packed {
        logic [EP_W-1:0] sel;
        logic            pend;
        logic [EP_W-1:0] pend_ep;
    } dec_st_t;

    dec_st_t q, d;

    always_comb begin
        d          = q;
        op_o       = OP_NONE;
        op_ep_o    = q.sel;
        op_stall_o = cmd_byte[0];
        if (cmd_valid) begin
            if (cmd_is_data) begin
                if (q.pend) begin
                    op_o    = OP_STATUS;
                    op_ep_o = q.pend_ep;
                end
                d.pend = 1'b0;
            end else begin
                d.pend = 1'b0;
                if (cmd_byte < NUM_EP_B) begin
                    d.sel = EP_W'(cmd_byte);
                end else if (cmd_byte >= CMD_STAT_BASE &&
                             cmd_byte < CMD_STAT_BASE + NUM_EP_B) begin
                    d.pend    = 1'b1;
                    d.pend_ep = EP_W'(cmd_byte - CMD_STAT_BASE);
                end else if (cmd_byte == CMD_VALIDATE) begin
                    op_o = OP_VALIDATE;
                end else if (cmd_byte == CMD_CLEAR) begin
                    op_o = OP_CLEAR;
                end else if (cmd_byte == CMD_ACKSETUP) begin
                    op_o = OP_ACKSETUP;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R7: the selected endpoint never leaves the implemented range
    assert_sel_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(q.sel) < NUM_EP) && (32'(q.pend_ep) < NUM_EP));

    // R8: a status op is only produced by a data byte that follows a status code
    assert_status_needs_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o == OP_STATUS) |-> (cmd_valid && cmd_is_data && q.pend));

endmodule

// File: rtl/ephs_pair.sv
module ephs_pair
    import ephs_pkg::*;
#(
    parameter int PAIR_IDX = 0,
    parameter int EP_W     = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_here,
    input  logic            bus_setup,
    input  logic            bus_out_done,
    input  logic            bus_in_token,
    input  logic            bus_pid_data1,
    input  op_e             op,
    input  logic [EP_W-1:0] op_ep,
    input  logic            op_stall,
    output logic            hs_valid_o,
    output logic [1:0]      hs_code_o,
    output logic            hs_data1_o,
    output logic            lock_o
);

    localparam int DIR_OUT = 0;
    localparam int DIR_IN  = 1;

    pair_st_t q, d;
    logic     cmd_hit;
    logic     cmd_dir;

    assign cmd_hit = (op != OP_NONE) && ((op_ep >> 1) == EP_W'(PAIR_IDX));
    assign cmd_dir = op_ep[0];

    always_comb begin
        d          = q;
        d.hs_valid = 1'b0;
        d.hs_code  = HS_ACK;
        d.hs_data1 = 1'b0;

        // bus events first
        if (bus_here && bus_setup) begin
            d.stall        = 2'b00;
            d.full[DIR_OUT] = 1'b1;
            d.full[DIR_IN]  = 1'b0;
            d.tog          = 2'b11;
            d.lock         = 1'b1;
            d.hs_valid     = 1'b1;
        end else if (bus_here && bus_out_done) begin
            d.hs_valid = 1'b1;
            if (q.stall[DIR_OUT]) begin
                d.hs_code = HS_STALL;
            end else if (q.full[DIR_OUT]) begin
                d.hs_code = HS_NAK;
            end else if (bus_pid_data1 == q.tog[DIR_OUT]) begin
                d.full[DIR_OUT] = 1'b1;
                d.tog[DIR_OUT]  = ~q.tog[DIR_OUT];
            end
        end else if (bus_here && bus_in_token) begin
            d.hs_valid = 1'b1;
            if (q.stall[DIR_IN]) begin
                d.hs_code = HS_STALL;
            end else if (!q.full[DIR_IN]) begin
                d.hs_code = HS_NAK;
            end else begin
                d.hs_data1     = q.tog[DIR_IN];
                d.full[DIR_IN] = 1'b0;
                d.tog[DIR_IN]  = ~q.tog[DIR_IN];
            end
        end

        // then the command, seeing the lock the bus event left
        if (cmd_hit) begin
            unique case (op)
                OP_VALIDATE: if (!d.lock) d.full[cmd_dir] = 1'b1;
                OP_CLEAR:    if (!d.lock) d.full[cmd_dir] = 1'b0;
                OP_ACKSETUP: d.lock = 1'b0;
                OP_STATUS: begin
                    if (op_stall) begin
                        d.stall[cmd_dir] = 1'b1;
                    end else begin
                        d.stall[cmd_dir] = 1'b0;
                        d.full[cmd_dir]  = 1'b0;
                        d.tog[cmd_dir]   = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign hs_valid_o = q.hs_valid;
    assign hs_code_o  = q.hs_code;
    assign hs_data1_o = q.hs_data1;
    assign lock_o     = q.lock;

    assert_setup_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_here && bus_setup && !cmd_hit) |=>
        (q.hs_valid && q.hs_code == HS_ACK && q.lock &&
         q.stall == 2'b00 && q.full == 2'b01 && q.tog == 2'b11));

    assert_out_full_nak_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_here && bus_out_done && !q.stall[0] && q.full[0]) |=>
        (q.hs_valid && q.hs_code == HS_NAK));

    assert_pid_mismatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_here && bus_out_done && !q.stall[0] && !q.full[0] &&
         (bus_pid_data1 != q.tog[0]) && !cmd_hit) |=>
        (q.hs_code == HS_ACK && !q.full[0] && q.tog[0] == $past(q.tog[0])));

    assert_stall_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_here && ((bus_out_done && q.stall[0]) || (bus_in_token && q.stall[1]))) |=>
        (q.hs_valid && q.hs_code == HS_STALL));

    assert_lock_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && (op == OP_VALIDATE || op == OP_CLEAR) && q.lock && !bus_here) |=>
        (q.full == $past(q.full)));

    assert_in_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_here && bus_in_token && !q.stall[1] && q.full[1] && !cmd_hit) |=>
        (q.tog[1] != $past(q.tog[1]) && !q.full[1] && q.hs_code == HS_ACK));

endmodule

// File: rtl/usb_ep_hs_ctrl.sv
module usb_ep_hs_ctrl
    import ephs_pkg::*;
#(
    parameter int NUM_PAIRS = 3,
    parameter int PAIR_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic                 cmd_is_data,
    input  logic [7:0]           cmd_byte,
    input  logic                 bus_setup,
    input  logic                 bus_out_done,
    input  logic                 bus_in_token,
    input  logic [PAIR_W-1:0]    bus_pair,
    input  logic                 bus_pid_data1,
    output logic                 hs_valid,
    output logic [1:0]           hs_code,
    output logic                 hs_data1,
    output logic [NUM_PAIRS-1:0] setup_lock
);

    localparam int NUM_EP = 2 * NUM_PAIRS;
    localparam int EP_W   = $clog2(NUM_EP);

    op_e             op;
    logic [EP_W-1:0] op_ep;
    logic            op_stall;

    logic [NUM_PAIRS-1:0] pv;
    logic [NUM_PAIRS-1:0] pd;
    logic [1:0]           pc [NUM_PAIRS];

    ephs_cmd_decode #(.NUM_EP(NUM_EP), .EP_W(EP_W)) i_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_is_data(cmd_is_data),
        .cmd_byte   (cmd_byte),
        .op_o       (op),
        .op_ep_o    (op_ep),
        .op_stall_o (op_stall)
    );

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        ephs_pair #(.PAIR_IDX(g), .EP_W(EP_W)) i_pair (
            .clk          (clk),
            .rst_n        (rst_n),
            .bus_here     (bus_pair == PAIR_W'(g)),
            .bus_setup    (bus_setup),
            .bus_out_done (bus_out_done),
            .bus_in_token (bus_in_token),
            .bus_pid_data1(bus_pid_data1),
            .op           (op),
            .op_ep        (op_ep),
            .op_stall     (op_stall),
            .hs_valid_o   (pv[g]),
            .hs_code_o    (pc[g]),
            .hs_data1_o   (pd[g]),
            .lock_o       (setup_lock[g])
        );
    end

    always_comb begin
        hs_valid = 1'b0;
        hs_code  = 2'b00;
        hs_data1 = 1'b0;
        for (int i = 0; i < NUM_PAIRS; i++) begin
            hs_valid = hs_valid | pv[i];
            hs_code  = hs_code  | pc[i];
            hs_data1 = hs_data1 | pd[i];
        end
    end

    assert_bus_single_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_setup, bus_out_done, bus_in_token}));

    assert_one_handshake_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pv));

    assert_event_answered_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_setup || bus_out_done || bus_in_token) |=> hs_valid);

    assert_quiet_no_hs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_setup || bus_out_done || bus_in_token) |=> !hs_valid);

endmodule

// File: tb/test_usb_ep_hs_ctrl.sv
module test_usb_ep_hs_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0, cmd_is_data = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       bus_setup = 1'b0, bus_out_done = 1'b0, bus_in_token = 1'b0;
    logic [1:0] bus_pair = 2'd0;
    logic       bus_pid_data1 = 1'b0;
    logic       hs_valid, hs_data1;
    logic [1:0] hs_code;
    logic [2:0] setup_lock;

    int tests = 0;
    int fails = 0;

    // reference state
    logic m_stall [6];
    logic m_full  [6];
    logic m_tog   [6];
    logic [2:0] m_lock;
    int   m_sel, m_pend_ep;
    logic m_pend;

    always #2.5ns clk = ~clk;

    usb_ep_hs_ctrl i_usb_ep_hs_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_is_data(cmd_is_data), .cmd_byte(cmd_byte),
        .bus_setup(bus_setup), .bus_out_done(bus_out_done), .bus_in_token(bus_in_token),
        .bus_pair(bus_pair), .bus_pid_data1(bus_pid_data1),
        .hs_valid(hs_valid), .hs_code(hs_code), .hs_data1(hs_data1),
        .setup_lock(setup_lock)
    );

    task automatic report(input logic ok, input string tag, input string what);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    task automatic step(input logic cv, input logic cd, input logic [7:0] cb,
                        input logic su, input logic od, input logic it,
                        input int bp, input logic pid, input string tag);
        logic       ev, ed;
        logic [1:0] ec;
        int         eo, ei, e;
        cmd_valid = cv; cmd_is_data = cd; cmd_byte = cb;
        bus_setup = su; bus_out_done = od; bus_in_token = it;
        bus_pair = 2'(bp); bus_pid_data1 = pid;
        ev = su | od | it; ec = 2'b00; ed = 1'b0;
        eo = 2 * bp; ei = eo + 1;
        if (su) begin
            m_stall[eo] = 0; m_stall[ei] = 0;
            m_full[eo] = 1;  m_full[ei] = 0;
            m_tog[eo] = 1;   m_tog[ei] = 1;
            m_lock[bp] = 1;
        end else if (od) begin
            if (m_stall[eo]) ec = 2'b10;
            else if (m_full[eo]) ec = 2'b01;
            else if (pid == m_tog[eo]) begin m_full[eo] = 1; m_tog[eo] = ~m_tog[eo]; end
        end else if (it) begin
            if (m_stall[ei]) ec = 2'b10;
            else if (!m_full[ei]) ec = 2'b01;
            else begin ed = m_tog[ei]; m_full[ei] = 0; m_tog[ei] = ~m_tog[ei]; end
        end
        if (cv) begin
            if (cd) begin
                if (m_pend) begin
                    e = m_pend_ep;
                    if (cb[0]) m_stall[e] = 1;
                    else begin m_stall[e] = 0; m_full[e] = 0; m_tog[e] = 0; end
                end
                m_pend = 0;
            end else begin
                m_pend = 0;
                if (cb < 8'd6) m_sel = int'(cb);
                else if (cb >= 8'h40 && cb < 8'h46) begin m_pend = 1; m_pend_ep = int'(cb) - 8'h40; end
                else if (cb == 8'hFA) begin if (!m_lock[m_sel/2]) m_full[m_sel] = 1; end
                else if (cb == 8'hF2) begin if (!m_lock[m_sel/2]) m_full[m_sel] = 0; end
                else if (cb == 8'hF1) m_lock[m_sel/2] = 0;
            end
        end
        @(negedge clk);
        report(hs_valid === ev && (!ev || (hs_code === ec && hs_data1 === ed)) &&
               setup_lock === m_lock, tag,
               $sformatf("valid=%0b code=%0b d1=%0b lock=%b exp valid=%0b code=%0b d1=%0b lock=%b",
                         hs_valid, hs_code, hs_data1, setup_lock, ev, ec, ed, m_lock));
        cmd_valid = 0; bus_setup = 0; bus_out_done = 0; bus_in_token = 0;
    endtask

    task automatic cmd(input logic [7:0] b, input string tag);
        step(1, 0, b, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic dat(input logic [7:0] b, input string tag);
        step(1, 1, b, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic bout(input int p, input logic pid, input string tag);
        step(0, 0, 8'h00, 0, 1, 0, p, pid, tag);
    endtask
    task automatic bin(input int p, input string tag);
        step(0, 0, 8'h00, 0, 0, 1, p, 0, tag);
    endtask

    initial begin
        #1ms;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] b;
        int k;
        for (int i = 0; i < 6; i++) begin m_stall[i] = 0; m_full[i] = 0; m_tog[i] = 0; end
        m_lock = 3'b000; m_sel = 0; m_pend = 0; m_pend_ep = 0;
        void'($urandom(32'h5EED_0D12));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        report(hs_valid === 1'b0 && setup_lock === 3'b000, "R1",
               $sformatf("valid=%0b lock=%b exp 0/000", hs_valid, setup_lock));
        bin(0, "R1");                 // empty IN -> NAK
        // R3: accept DATA0, then NAK while full
        bout(0, 0, "R3");
        bout(0, 1, "R3");
        // R5: clear frees buffer, next expected is DATA1
        cmd(8'h00, "R7"); cmd(8'hF2, "R5");
        bout(0, 1, "R5");
        // R4: mismatched PID dropped
        cmd(8'hF2, "R5");
        bout(0, 1, "R4");
        bout(0, 0, "R4");
        // R6: IN validate and toggle
        bin(1, "R6");
        cmd(8'h03, "R7"); cmd(8'hFA, "R6");
        bin(1, "R6"); bin(1, "R6");
        cmd(8'hFA, "R6"); bin(1, "R6");
        // R8: stall IN of pair 1, OUT stays usable; reserved bits ignored
        cmd(8'h43, "R8"); dat(8'hFF, "R8");
        bin(1, "R8"); bout(1, 0, "R8");
        dat(8'h01, "R8"); bin(1, "R8");   // stray data byte ignored
        // R9: re-init, toggle back to DATA0
        cmd(8'h43, "R9"); dat(8'h00, "R9");
        cmd(8'h03, "R7"); cmd(8'hFA, "R9"); bin(1, "R9");
        cmd(8'h42, "R9"); dat(8'hFE, "R9"); bout(1, 0, "R9");
        // R10/R11: SETUP un-stalls and locks
        cmd(8'h42, "R10"); dat(8'h01, "R10"); bout(1, 0, "R10");
        step(0, 0, 8'h00, 1, 0, 0, 1, 0, "R10");
        bout(1, 1, "R10");
        cmd(8'h02, "R7"); cmd(8'hF2, "R11"); bout(1, 1, "R11");
        cmd(8'h03, "R7"); cmd(8'hFA, "R11"); bin(1, "R11");
        cmd(8'hF1, "R11");
        cmd(8'hFA, "R10"); bin(1, "R10");
        // R12: SETUP with simultaneous validate
        cmd(8'h01, "R7");
        step(1, 0, 8'hFA, 1, 0, 0, 0, 0, "R12");
        cmd(8'hF1, "R12"); bin(0, "R12");
        // R7: out-of-range select ignored
        cmd(8'h05, "R7"); cmd(8'h07, "R7"); cmd(8'hFA, "R7"); bin(2, "R7");
        // random mix
        for (int n = 0; n < 4000; n++) begin
            k = int'($urandom % 16);
            case ($urandom % 10)
                0, 1, 2, 3: b = 8'($urandom % 6);
                4, 5:       b = 8'h40 + 8'($urandom % 6);
                6:          b = 8'hFA;
                7:          b = 8'hF2;
                8:          b = 8'hF1;
                default:    b = 8'($urandom);
            endcase
            step(($urandom % 3) != 0, ($urandom % 4) == 0, b,
                 k == 0, k >= 1 && k <= 5, k >= 6 && k <= 10,
                 int'($urandom % 3), 1'($urandom),
                 (k == 0) ? "R10" : (k <= 5) ? "R3" : (k <= 10) ? "R6" : "R11");
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule